// File: doc/BRIEF.md
# Leading Zero Counter

This block takes an 8-bit word and reports how many zero bits come before the first set bit, scanning from the most significant end. The caller guarantees that the word has at least one set bit, so the count never exceeds 7 and fits in a 3-bit result. There is no zero flag. The block has no clock, no registers and no pipeline stage, so the result follows the input combinationally.

The block does not evaluate one flat 8-input function. It splits the word into an upper and a lower half and runs a small counter on each. Each half counter gives a 2-bit count and a flag that is set when the half is all zero. A merge step then picks one result. If the upper half holds a set bit, the upper count is the answer and the result's top bit is 0. Otherwise the top bit is 1 and the lower count fills the low bits. The same split-and-merge step can be repeated for wider words, and it grows more slowly than a two-level circuit. For the out-of-contract all-zero word, the output is the fixed value 7, so that simulation stays deterministic.

Top module: `lead_zero_cnt8`

## Requirements
- R1: For every nonzero 8-bit input, `lz_cnt` equals the number of consecutive zero bits starting at bit 7, stopping at the first set bit.
- R2: Any input with bit 7 set yields 0.
- R3: Input 8'b00010100 yields 3, and input 8'b00000100 yields 5.
- R4: When bits 7..4 are not all zero, `lz_cnt[2]` is 0, and `lz_cnt[1:0]` is the leading-zero count of bits 7..4 alone.
- R5: When bits 7..4 are all zero, `lz_cnt[2]` is 1, and `lz_cnt[1:0]` is the leading-zero count of bits 3..0 (3 when those are also zero).
- R6: An input with only bit 0 set yields 7, and the all-zero input also yields 7.
- R7: For a nonzero input, bit (7 - `lz_cnt`) of the input is 1, and every bit above it is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| din | input | 8 | Word to scan, bit 7 is the most significant |
| lz_cnt | output | 3 | Number of leading zeros of `din` |

## Verification
The bench targets the seam between the two halves. This includes inputs 8'h10 and 8'h08, where a merge that picks the wrong half or forgets the top bit gives 3 and 4 mixed up, or 0 in place of 4. It drives 8'h01 and 8'h00 to catch a lower-half counter that saturates at the wrong value or mishandles its all-zero case: such a design would report 6, or garbage, instead of 7. Single set bits at 7 and at 4 expose a half counter that counts from the wrong end and would return 3 rather than 0. An exhaustive sweep of all 256 words, against a scan written in the bench, catches any remaining pattern in which lower bits wrongly influence the count.

// File: rtl/lead_zero_cnt8.sv
module lead_zero_cnt8 #(
  parameter int W = 8
) (
  input  logic [W-1:0]         din,
  output logic [$clog2(W)-1:0] lz_cnt
);
  localparam int HALF  = W / 2;
  localparam int HCW   = $clog2(HALF);
  localparam int CW    = $clog2(W);

  logic [HCW-1:0] part_cnt [2];
  logic [1:0]     part_zero;

  function automatic logic [HCW-1:0] half_lz(input logic [HALF-1:0] v);
    logic [HCW-1:0] n;
    logic           seen;
    n    = HCW'(HALF - 1);
    seen = 1'b0;
    for (int i = HALF - 1; i >= 0; i--) begin
      if (v[i] && !seen) begin
        n    = HCW'(HALF - 1 - i);
        seen = 1'b1;
      end
    end
    return n;
  endfunction

  for (genvar g = 0; g < 2; g++) begin : g_half
    assign part_cnt[g]  = half_lz(din[g*HALF +: HALF]);
    assign part_zero[g] = ~|din[g*HALF +: HALF];
  end

  assign lz_cnt = part_zero[1] ? {1'b1, part_cnt[0]} : {1'b0, part_cnt[1]};

  always_comb begin
    if (!$isunknown(din)) begin
      // R2
      msb_zero_chk: assert (!din[W-1] || lz_cnt == '0);
      // R6
      floor_cnt_chk: assert ((din > 8'd1) || lz_cnt == CW'(W - 1));
      // R7
      first_one_chk: assert (din == '0 || din[CW'(CW'(W - 1) - lz_cnt)]);
      // R7
      above_zero_chk: assert (din == '0 || lz_cnt == '0 ||
                              (din >> (CW + 1)'((CW + 1)'(W) - {1'b0, lz_cnt})) == '0);
      // R5
      upper_sel_chk: assert (lz_cnt[CW-1] == (din[W-1:HALF] == '0));
    end
  end
endmodule

// File: tb/sim_lead_zero_cnt8.sv
module sim_lead_zero_cnt8;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] din = 8'h80;
  logic [2:0] lz_cnt;
  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  lead_zero_cnt8 u0 (.din(din), .lz_cnt(lz_cnt));

  function automatic int ref_lz(input logic [7:0] v);
    for (int i = 7; i >= 0; i--)
      if (v[i]) return 7 - i;
    return 7;
  endfunction

  task automatic check(input string req, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s din=%08b got=%0d expected=%0d", req, din, got, exp);
    end
  endtask

  task automatic apply(input logic [7:0] v);
    @(posedge clk);
    din = v;
    @(negedge clk);
  endtask

  initial begin
    repeat (2) @(posedge clk);
    rst = 1'b0;
    @(negedge clk);
    // reset-time value with din = 8'h80
    check("R2", int'(lz_cnt), 0);

    apply(8'b0001_0100); check("R3", int'(lz_cnt), 3);
    apply(8'b0000_0100); check("R3", int'(lz_cnt), 5);
    apply(8'h80);        check("R2", int'(lz_cnt), 0);
    apply(8'hFF);        check("R2", int'(lz_cnt), 0);
    apply(8'h10);        check("R4", int'(lz_cnt), 3);
    apply(8'h08);        check("R5", int'(lz_cnt), 4);
    apply(8'h01);        check("R6", int'(lz_cnt), 7);
    apply(8'h00);        check("R6", int'(lz_cnt), 7);
    apply(8'h4F);        check("R4", int'(lz_cnt), 1);
    apply(8'h0A);        check("R5", int'(lz_cnt), 4);

    for (int v = 1; v < 256; v++) begin
      apply(8'(v));
      check("R1", int'(lz_cnt), ref_lz(8'(v)));
      if (v >= 16) begin
        check("R4", int'(lz_cnt[2]), 0);
        check("R4", int'(lz_cnt[1:0]), ref_lz({din[7:4], 4'h0}));
      end else begin
        check("R5", int'(lz_cnt[2]), 1);
        check("R5", int'(lz_cnt[1:0]), ref_lz({din[3:0], 4'h0}));
      end
      check("R7", int'(din >> (7 - int'(lz_cnt))), 1);
    end
    done = 1'b1;
  end

  initial begin
    while (!done && cycles < 5000) begin
      @(posedge clk);
      cycles++;
    end
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired after %0d cycles", cycles);
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule